// File: doc/BRIEF.md
# Inter-Processor Doorbell Message Router

This block lets any of N processor contexts signal other contexts through doorbell messages. Each context presents a one-cycle operation: a send or a clear, together with a 32-bit message word. The router decodes the word and updates a small set of pending doorbell flags held for every context. Each context's interrupt request is high whenever any of its flags is set.

Two message formats are supported, selected by `fmt_server`. The embedded format knows a normal and a critical doorbell. A send in this format reaches every context whose configured processor ID equals the tag, or every context when the broadcast bit is set. The server format knows a single hypervisor doorbell, type 5. A send in this format reaches only tag-matching contexts and never broadcasts. All other type codes, including the guest doorbell types, do nothing.

A clear never travels: it removes the decoded flag from the issuing context only. The pending flags are plain registers with no state machine around them. Each flag's next value is formed from the clears and sets of the current cycle, and a set wins over a clear.

Top module: `dbr_router`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every pending flag and every `irq` bit is 0.
- R2: In embedded format (`fmt_server`=0), a send of type 0 sets the normal flag, and a send of type 1 sets the critical flag, of each targeted context. The flag appears at the clock edge that samples the operation. The type sits in bits [31:27] of the message word.
- R3: In embedded format, every type other than 0 and 1 is ignored, both for sends and for clears. This includes the guest doorbell types 2, 3 and 4.
- R4: In embedded format, a send targets every context whose `ctx_pir` slice equals message bits [13:0]. When message bit 26 (broadcast) is 1, it targets all contexts.
- R5: In server format (`fmt_server`=1), a send of type 5 sets the hypervisor flag of each context whose processor ID matches the tag. Every other type is a no-op.
- R6: In server format, message bit 26 has no effect: a send without a tag match changes nothing.
- R7: A clear resets the decoded flag of the issuing context only, whatever the tag and broadcast fields hold.
- R8: `irq[c]` is 1 exactly when context c has at least one pending flag set.
- R9: Sends issued by several contexts in the same cycle all take effect, merged by OR.
- R10: When a clear and a set hit the same flag in the same cycle, the flag ends up set.
- R11: In a cycle without any valid operation, all flags hold their values, including across a change of `fmt_server`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_server | input | 1 | 0: embedded message format, 1: server message format |
| op_valid | input | N_CTX | One bit per context: that context issues an operation this cycle |
| op_clear | input | N_CTX | Per context: 1 means clear, 0 means send |
| op_msg | input | N_CTX*32 | Message word of each context, context c in slice [c*32 +: 32] |
| ctx_pir | input | N_CTX*14 | Processor ID of each context, context c in slice [c*14 +: 14] |
| pend_norm | output | N_CTX | Normal doorbell pending flag per context |
| pend_crit | output | N_CTX | Critical doorbell pending flag per context |
| pend_hyp | output | N_CTX | Hypervisor doorbell pending flag per context |
| irq | output | N_CTX | Interrupt request per context |

## Verification
The bound checker watches several properties on every cycle:
- the normal and critical flags never rise in server format, and the hypervisor flag never rises in embedded format;
- a flag never falls unless its own context issued a clear;
- all flags are frozen in idle cycles;
- a rising flag brings its interrupt request with it.

Some behaviour depends on message contents and configuration, so only the bench's scenarios can show it. This covers tag matching against duplicated processor IDs, broadcast reaching every context, reserved and guest types being inert, and a set beating a clear in the same cycle. The bench compares these against its reference model, both in directed cases and in a random phase.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    localparam int KIND_W   = 3;
    localparam int K_NORM   = 0;
    localparam int K_CRIT   = 1;
    localparam int K_HYP    = 2;
    localparam int TYPE_W   = 5;
    localparam logic [TYPE_W-1:0] MT_NORM = 5'd0;
    localparam logic [TYPE_W-1:0] MT_CRIT = 5'd1;
    localparam logic [TYPE_W-1:0] MT_HYP  = 5'd5;
    typedef logic [KIND_W-1:0] db_kind_t;
endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
    import dbr_pkg::*;
#(
    parameter int MSG_W     = 32,
    parameter int TAG_W     = 14,
    parameter int TYPE_LSB  = 27,
    parameter int BCAST_BIT = 26
) (
    input  logic [MSG_W-1:0] msg,
    input  logic             server,
    output db_kind_t         kind,
    output logic             bcast,
    output logic [TAG_W-1:0] tag
);
    logic [TYPE_W-1:0] typ;
    logic              pad_unused;

    assign typ        = msg[TYPE_LSB +: TYPE_W];
    assign tag        = msg[TAG_W-1:0];
    assign bcast      = !server && msg[BCAST_BIT];
    assign pad_unused = ^msg;

    always_comb begin
        kind = '0;
        if (server) begin
            if (typ == MT_HYP) kind[K_HYP] = 1'b1;
        end else begin
            case (typ)
                MT_NORM: kind[K_NORM] = 1'b1;
                MT_CRIT: kind[K_CRIT] = 1'b1;
                default: kind = '0;
            endcase
        end
    end
endmodule

// File: rtl/dbr_match.sv
module dbr_match #(
    parameter int N_CTX = 4,
    parameter int TAG_W = 14
) (
    input  logic [TAG_W-1:0]       tag,
    input  logic                   bcast,
    input  logic [N_CTX*TAG_W-1:0] pir,
    output logic [N_CTX-1:0]       hit
);
    for (genvar c = 0; c < N_CTX; c++) begin : g_cmp
        assign hit[c] = bcast || (pir[c*TAG_W +: TAG_W] == tag);
    end
endmodule

// File: rtl/dbr_slot.sv
module dbr_slot
    import dbr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  db_kind_t set_i,
    input  db_kind_t clr_i,
    output db_kind_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_i) | set_i;
    end
endmodule

// File: rtl/dbr_router.sv
module dbr_router
    import dbr_pkg::*;
#(
    parameter int N_CTX = 4,
    parameter int TAG_W = 14,
    parameter int MSG_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fmt_server,
    input  logic [N_CTX-1:0]       op_valid,
    input  logic [N_CTX-1:0]       op_clear,
    input  logic [N_CTX*MSG_W-1:0] op_msg,
    input  logic [N_CTX*TAG_W-1:0] ctx_pir,
    output logic [N_CTX-1:0]       pend_norm,
    output logic [N_CTX-1:0]       pend_crit,
    output logic [N_CTX-1:0]       pend_hyp,
    output logic [N_CTX-1:0]       irq
);
    localparam int TYPE_LSB  = MSG_W - TYPE_W;
    localparam int BCAST_BIT = TYPE_LSB - 1;

    db_kind_t         kind  [N_CTX];
    logic             bcast [N_CTX];
    logic [TAG_W-1:0] tag   [N_CTX];
    logic [N_CTX-1:0] hit   [N_CTX];
    db_kind_t         set_m [N_CTX];
    db_kind_t         clr_m [N_CTX];
    db_kind_t         q     [N_CTX];

    for (genvar s = 0; s < N_CTX; s++) begin : g_src
        dbr_decode #(
            .MSG_W(MSG_W), .TAG_W(TAG_W),
            .TYPE_LSB(TYPE_LSB), .BCAST_BIT(BCAST_BIT)
        ) u_dec (
            .msg   (op_msg[s*MSG_W +: MSG_W]),
            .server(fmt_server),
            .kind  (kind[s]),
            .bcast (bcast[s]),
            .tag   (tag[s])
        );
        dbr_match #(.N_CTX(N_CTX), .TAG_W(TAG_W)) u_match (
            .tag  (tag[s]),
            .bcast(bcast[s]),
            .pir  (ctx_pir),
            .hit  (hit[s])
        );
    end

    // merge all senders per destination; clears stay local to the issuer
    always_comb begin
        for (int c = 0; c < N_CTX; c++) begin
            set_m[c] = '0;
            for (int s = 0; s < N_CTX; s++) begin
                if (op_valid[s] && !op_clear[s] && hit[s][c])
                    set_m[c] = set_m[c] | kind[s];
            end
            clr_m[c] = (op_valid[c] && op_clear[c]) ? kind[c] : '0;
        end
    end

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        dbr_slot u_slot (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(set_m[c]),
            .clr_i(clr_m[c]),
            .q    (q[c])
        );
        assign pend_norm[c] = q[c][K_NORM];
        assign pend_crit[c] = q[c][K_CRIT];
        assign pend_hyp[c]  = q[c][K_HYP];
        assign irq[c]       = |q[c];
    end
endmodule

// File: rtl/dbr_router_chk.sv
module dbr_router_chk #(
    parameter int N_CTX = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fmt_server,
    input logic [N_CTX-1:0] op_valid,
    input logic [N_CTX-1:0] op_clear,
    input logic [N_CTX-1:0] pend_norm,
    input logic [N_CTX-1:0] pend_crit,
    input logic [N_CTX-1:0] pend_hyp,
    input logic [N_CTX-1:0] irq
);
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(|op_valid) |=> ($stable(pend_norm) && $stable(pend_crit) && $stable(pend_hyp)));

    p_srv_no_emb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_server |=> (((pend_norm & ~$past(pend_norm)) == '0) &&
                        ((pend_crit & ~$past(pend_crit)) == '0)));

    p_emb_no_hyp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_server |=> ((pend_hyp & ~$past(pend_hyp)) == '0));

    for (genvar c = 0; c < N_CTX; c++) begin : g_c
        p_clear_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(pend_norm[c]) || $fell(pend_crit[c]) || $fell(pend_hyp[c]))
            |-> $past(op_valid[c] && op_clear[c]));

        p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(pend_norm[c]) || $rose(pend_crit[c]) || $rose(pend_hyp[c])) |-> irq[c]);
    end
endmodule

bind dbr_router dbr_router_chk #(.N_CTX(N_CTX)) u_chk (.*);

// File: tb/sim_dbr_router.sv
module sim_dbr_router;
    localparam int N = 4;
    localparam int TW = 14;
    localparam int MW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fmt_server = 1'b0;
    logic [N-1:0]    op_valid = '0;
    logic [N-1:0]    op_clear = '0;
    logic [N*MW-1:0] op_msg = '0;
    logic [N*TW-1:0] ctx_pir;
    logic [N-1:0]    pend_norm, pend_crit, pend_hyp, irq;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;

    logic [N-1:0] m_n = '0, m_c = '0, m_h = '0;
    logic [N-1:0] t_n, t_c, t_h;

    always #5 clk = ~clk;

    assign ctx_pir = {14'h022, 14'h022, 14'h011, 14'h010};

    dbr_router #(.N_CTX(N), .TAG_W(TW), .MSG_W(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .fmt_server(fmt_server),
        .op_valid(op_valid), .op_clear(op_clear), .op_msg(op_msg),
        .ctx_pir(ctx_pir), .pend_norm(pend_norm), .pend_crit(pend_crit),
        .pend_hyp(pend_hyp), .irq(irq)
    );

    // behavioural reference: clears first, then sets, so a set wins
    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = '0; m_c = '0; m_h = '0;
        end else begin
            t_n = m_n; t_c = m_c; t_h = m_h;
            for (int s = 0; s < N; s++) begin
                if (op_valid[s] && op_clear[s]) begin
                    case ({fmt_server, op_msg[s*MW+27 +: 5]})
                        6'd0:  t_n[s] = 1'b0;
                        6'd1:  t_c[s] = 1'b0;
                        6'd37: t_h[s] = 1'b0;
                        default: ;
                    endcase
                end
            end
            for (int s = 0; s < N; s++) begin
                if (op_valid[s] && !op_clear[s]) begin
                    for (int c = 0; c < N; c++) begin
                        if ((op_msg[s*MW +: TW] == ctx_pir[c*TW +: TW]) ||
                            (!fmt_server && op_msg[s*MW+26])) begin
                            case ({fmt_server, op_msg[s*MW+27 +: 5]})
                                6'd0:  t_n[c] = 1'b1;
                                6'd1:  t_c[c] = 1'b1;
                                6'd37: t_h[c] = 1'b1;
                                default: ;
                            endcase
                        end
                    end
                end
            end
            m_n = t_n; m_c = t_c; m_h = t_h;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            n_chk++;
            if (pend_norm !== m_n || pend_crit !== m_c || pend_hyp !== m_h ||
                irq !== (m_n | m_c | m_h)) begin
                n_bad++;
                $display("FAIL %s model: actual n=%b c=%b h=%b irq=%b expected n=%b c=%b h=%b irq=%b",
                         cur_req, pend_norm, pend_crit, pend_hyp, irq,
                         m_n, m_c, m_h, m_n | m_c | m_h);
            end
        end
    end

    task automatic chk4(input string req, input string what,
                        input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [N-1:0] en,
                           input logic [N-1:0] ec, input logic [N-1:0] eh);
        chk4(req, "norm", pend_norm, en);
        chk4(req, "crit", pend_crit, ec);
        chk4(req, "hyp", pend_hyp, eh);
        chk4(req, "irq", irq, en | ec | eh);
    endtask

    task automatic put(input int s, input logic clr, input logic [4:0] ty,
                       input logic bc, input logic [13:0] tg);
        op_valid[s] = 1'b1;
        op_clear[s] = clr;
        op_msg[s*MW +: MW] = {ty, bc, 12'd0, tg};
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        op_valid = '0;
        op_clear = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1", 4'b0000, 4'b0000, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 4'b0000, 4'b0000, 4'b0000);
        cmp_on = 1'b1;

        cur_req = "R2";
        put(0, 0, 5'd0, 0, 14'h011); step();
        chk_all("R2", 4'b0010, 4'b0000, 4'b0000);
        put(1, 0, 5'd1, 0, 14'h022); step();
        chk_all("R4", 4'b0010, 4'b1100, 4'b0000);

        cur_req = "R3";
        put(0, 0, 5'd2, 1, 14'h3FFF); put(1, 0, 5'd3, 1, 14'h010);
        put(2, 0, 5'd4, 1, 14'h011); put(3, 0, 5'd7, 1, 14'h022); step();
        chk_all("R3", 4'b0010, 4'b1100, 4'b0000);
        put(0, 0, 5'd5, 1, 14'h010); step();
        chk_all("R3", 4'b0010, 4'b1100, 4'b0000);

        cur_req = "R4";
        put(2, 0, 5'd0, 1, 14'h3FFF); step();
        chk_all("R4", 4'b1111, 4'b1100, 4'b0000);

        cur_req = "R7";
        put(1, 1, 5'd0, 0, 14'h010); step();
        chk_all("R7", 4'b1101, 4'b1100, 4'b0000);
        put(0, 1, 5'd3, 1, 14'h010); step();
        chk_all("R3", 4'b1101, 4'b1100, 4'b0000);

        cur_req = "R5";
        fmt_server = 1'b1;
        put(2, 0, 5'd5, 0, 14'h010); step();
        chk_all("R5", 4'b1101, 4'b1100, 4'b0001);
        put(2, 0, 5'd0, 0, 14'h011); put(3, 0, 5'd1, 0, 14'h022); step();
        chk_all("R5", 4'b1101, 4'b1100, 4'b0001);

        cur_req = "R6";
        put(0, 0, 5'd5, 1, 14'h3FFF); step();
        chk_all("R6", 4'b1101, 4'b1100, 4'b0001);

        cur_req = "R9";
        put(0, 0, 5'd5, 0, 14'h011); put(1, 0, 5'd5, 0, 14'h022); step();
        chk_all("R9", 4'b1101, 4'b1100, 4'b1111);

        cur_req = "R10";
        put(3, 1, 5'd5, 0, 14'h000); put(0, 0, 5'd5, 0, 14'h022);
        put(1, 1, 5'd5, 0, 14'h000); step();
        chk_all("R10", 4'b1101, 4'b1100, 4'b1101);
        fmt_server = 1'b0;
        put(3, 1, 5'd1, 0, 14'h000); put(0, 0, 5'd1, 0, 14'h022); step();
        chk_all("R10", 4'b1101, 4'b1100, 4'b1101);

        cur_req = "R11";
        step(); fmt_server = 1'b1; step(); fmt_server = 1'b0; step();
        chk_all("R11", 4'b1101, 4'b1100, 4'b1101);

        cur_req = "R8";
        for (int s = 0; s < N; s++) put(s, 1, 5'd0, 1, 14'h3FFF);
        step();
        chk_all("R7", 4'b0000, 4'b1100, 4'b1101);
        for (int s = 0; s < N; s++) put(s, 1, 5'd1, 0, 14'h010);
        step();
        fmt_server = 1'b1;
        for (int s = 0; s < N; s++) put(s, 1, 5'd5, 0, 14'h011);
        step();
        chk_all("R8", 4'b0000, 4'b0000, 4'b0000);

        cur_req = "R9";
        for (int i = 0; i < 400; i++) begin
            fmt_server = $urandom_range(0, 1) == 1;
            for (int s = 0; s < N; s++) begin
                if ($urandom_range(0, 2) != 0) begin
                    logic [4:0] ty;
                    logic [13:0] tg;
                    case ($urandom_range(0, 6))
                        0: ty = 5'd0; 1: ty = 5'd1; 2: ty = 5'd2; 3: ty = 5'd3;
                        4: ty = 5'd4; 5: ty = 5'd5; default: ty = 5'd31;
                    endcase
                    case ($urandom_range(0, 3))
                        0: tg = 14'h010; 1: tg = 14'h011; 2: tg = 14'h022;
                        default: tg = 14'h3FFF;
                    endcase
                    put(s, $urandom_range(0, 2) == 0, ty, $urandom_range(0, 1) == 1, tg);
                end
            end
            step();
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule